// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the eight status bits of a serial communication controller. Five of them are event flags: transmit data empty, receive data full, overrun, framing error and parity error. The hardware sets them, and software may only clear them. Software clears a flag by reading it as one and then writing zero to its position. The remaining three bits are a transmit-done indication, the multiprocessor bit taken from the last received frame, and the multiprocessor bit to send with the next frame.

The CPU side has a read strobe, a write strobe with a data byte, and a read data byte that always shows the current contents. The transmitter and receiver datapaths drive single-cycle set and clear strobes. A transmit-enable level and a low-power hold level complete the inputs. Four interrupt requests leave the block, each gated by its own enable input.

Each clearable flag runs its own three-state machine:
- FLG_IDLE: the flag reads 0.
- FLG_PENDING: the flag reads 1 but has not been read as 1.
- FLG_ARMED: the flag reads 1 and has been read as 1.

The transitions are:
- SET: any state goes to FLG_PENDING on a set strobe or a forced set.
- SEE: FLG_PENDING goes to FLG_ARMED on a CPU read.
- WIPE: FLG_ARMED goes to FLG_IDLE on a CPU write of 0.
- HWCLR: FLG_PENDING or FLG_ARMED goes to FLG_IDLE on a hardware clear strobe.
- HOLD: low-power hold forces the state that matches the initial value.

Priority runs from the highest: HOLD, then SET, then HWCLR, then WIPE and SEE.

Top module: `serstat_flags`

## Requirements
- R1: `cpu_rdata` shows the register at all times. Its bits are: bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit done, bit 1 received multiprocessor bit, bit 0 multiprocessor bit to send.
- R2: Reset (`rst_n` low) gives 0x84. The same value is loaded on every clock edge while `lowpwr_hold` is 1, and strobes are ignored during that time.
- R3: A CPU write never sets bits 7 to 3. Writing 0xFF while they are 0 leaves them 0.
- R4: A CPU write of 0 to bit 7, 6, 5, 4 or 3 clears that flag only if the flag was read as 1 by an earlier `cpu_rd` (FLG_ARMED). Without that read, the write has no effect.
- R5: A successful clear consumes the read tag, and so does a new set of the flag. A later write of 0 without a new read has no effect. Writing 1 to an armed flag leaves it set and armed.
- R6: Transmit empty reads 1 on every cycle after an edge at which `tx_enable` was 0, whatever the clears. `txe_load` sets it.
- R7: `txe_dma_clr` clears transmit empty with no prior read, provided `tx_enable` is 1.
- R8: A set strobe wins over a CPU clear or a hardware clear of the same flag in the same cycle. The flag stays 1.
- R9: Bits 2 and 1 ignore CPU writes. Transmit done is set by `tend_set` and cleared by `tend_clr`, and the set wins. `mprx_load` copies `mprx_val` into bit 1.
- R10: Bit 0 is a plain read/write bit: it takes `cpu_wdata[0]` on each `cpu_wr`.
- R11: The interrupt requests are defined as follows:
  - `irq_txe` is bit 7 AND `ie_txe`.
  - `irq_rxf` is bit 6 AND `ie_rxf`.
  - `irq_err` is (bit 5 OR bit 4 OR bit 3) AND `ie_err`.
  - `irq_tend` is bit 2 AND `ie_tend`.
  - All four are combinational from the register and the enables.
- R12: Every strobe, read or write that a clock edge samples is visible on `cpu_rdata` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lowpwr_hold | input | 1 | Standby or module-stop hold; forces the initial value |
| tx_enable | input | 1 | Transmitter enabled; 0 holds transmit empty set |
| cpu_rd | input | 1 | CPU read strobe; arms the clear of flags that read 1 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register contents |
| txe_load | input | 1 | Data moved to shift register; sets transmit empty |
| txe_dma_clr | input | 1 | DMA wrote transmit data; clears transmit empty |
| rxf_set | input | 1 | Receive full set strobe |
| ovr_set | input | 1 | Overrun set strobe |
| frm_set | input | 1 | Framing error set strobe |
| par_set | input | 1 | Parity error set strobe |
| tend_set | input | 1 | Transmit done set strobe |
| tend_clr | input | 1 | Transmit done clear strobe |
| mprx_load | input | 1 | Load strobe for received multiprocessor bit |
| mprx_val | input | 1 | Received multiprocessor bit value |
| ie_txe | input | 1 | Enable for transmit-empty request |
| ie_rxf | input | 1 | Enable for receive-full request |
| ie_err | input | 1 | Enable for receive-error request |
| ie_tend | input | 1 | Enable for transmit-done request |
| irq_txe | output | 1 | Transmit-empty request |
| irq_rxf | output | 1 | Receive-full request |
| irq_err | output | 1 | Receive-error request |
| irq_tend | output | 1 | Transmit-done request |

## Verification
A flag machine stuck in FLG_PENDING shows up on the first armed write of zero, which leaves the bit at 1 one cycle later. A machine that enters FLG_ARMED without a read shows up on the first unarmed write, which wrongly drops the bit. Because `cpu_rdata` and the requests decode the state directly, any wrong state appears at the ports in the cycle after the faulty edge. The bench sweeps every clearable flag over every combination of prior read, written value and same-cycle set, then repeats the write without a new read.

// File: rtl/serstat_pkg.sv
package serstat_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_CLR  = 5;
    localparam logic [REG_W-1:0] INIT_VAL = 8'h84;

    // index of each clearable flag; register bit is REG_W-1-index
    localparam int IDX_TXE = 0;
    localparam int IDX_RXF = 1;
    localparam int IDX_OVR = 2;
    localparam int IDX_FRM = 3;
    localparam int IDX_PAR = 4;

    localparam int BIT_TEND = 2;
    localparam int BIT_MPRX = 1;
    localparam int BIT_MPTX = 0;

    typedef enum logic [1:0] {
        FLG_IDLE    = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_ARMED   = 2'd2
    } flag_state_t;

endpackage

// File: rtl/serstat_flag_fsm.sv
module serstat_flag_fsm
    import serstat_pkg::*;
#(
    parameter bit INIT_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic force_i,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    localparam flag_state_t INIT_ST = INIT_SET ? FLG_PENDING : FLG_IDLE;

    flag_state_t state_q, state_d;

    // next state: HOLD > SET > HWCLR > WIPE/SEE
    always_comb begin
        state_d = state_q;
        if (hold_i) begin
            state_d = INIT_ST;
        end else if (force_i || set_i) begin
            state_d = FLG_PENDING;
        end else begin
            unique case (state_q)
                FLG_IDLE: begin
                    state_d = FLG_IDLE;
                end
                FLG_PENDING: begin
                    if (hw_clr_i) begin
                        state_d = FLG_IDLE;
                    end else if (rd_i) begin
                        state_d = FLG_ARMED;
                    end
                end
                FLG_ARMED: begin
                    if (hw_clr_i) begin
                        state_d = FLG_IDLE;
                    end else if (wr_i && !wbit_i) begin
                        state_d = FLG_IDLE;
                    end
                end
                default: begin
                    state_d = FLG_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_ST;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        flag_o = (state_q != FLG_IDLE);
    end

    // R3: a cleared flag becomes 1 only through hardware
    a_r3_no_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i && !force_i && !(hold_i && INIT_SET)) |=> !flag_o);

    // R4: an unread flag survives any CPU write
    a_r4_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_PENDING && !hw_clr_i && !(hold_i && !INIT_SET)) |=> flag_o);

    // R8: a set strobe is never lost
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !(hold_i && !INIT_SET)) |=> flag_o);

    // R5: a flag just cleared by the CPU has no read tag
    a_r5_tag_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_ARMED && wr_i && !wbit_i && !set_i && !force_i && !hold_i)
        |=> (state_q != FLG_ARMED));

endmodule

// File: rtl/serstat_fixed_bits.sv
module serstat_fixed_bits
    import serstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic wr_i,
    input  logic wbit0_i,
    input  logic tend_set_i,
    input  logic tend_clr_i,
    input  logic mprx_load_i,
    input  logic mprx_val_i,
    output logic tend_o,
    output logic mprx_o,
    output logic mptx_o
);

    logic tend_q, mprx_q, mptx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tend_q <= INIT_VAL[BIT_TEND];
            mprx_q <= INIT_VAL[BIT_MPRX];
            mptx_q <= INIT_VAL[BIT_MPTX];
        end else if (hold_i) begin
            tend_q <= INIT_VAL[BIT_TEND];
            mprx_q <= INIT_VAL[BIT_MPRX];
            mptx_q <= INIT_VAL[BIT_MPTX];
        end else begin
            if (tend_set_i) begin
                tend_q <= 1'b1;
            end else if (tend_clr_i) begin
                tend_q <= 1'b0;
            end
            if (mprx_load_i) begin
                mprx_q <= mprx_val_i;
            end
            if (wr_i) begin
                mptx_q <= wbit0_i;
            end
        end
    end

    assign tend_o = tend_q;
    assign mprx_o = mprx_q;
    assign mptx_o = mptx_q;

    // R9: CPU writes leave the read-only bits alone
    a_r9_tend_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !tend_set_i && !tend_clr_i && !hold_i) |=> $stable(tend_o));

    a_r9_mprx_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !mprx_load_i && !hold_i) |=> $stable(mprx_o));

    // R10: the transmit multiprocessor bit follows the written value
    a_r10_mptx_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !hold_i) |=> (mptx_o == $past(wbit0_i)));

endmodule

// File: rtl/serstat_irq.sv
module serstat_irq
    import serstat_pkg::*;
(
    input  logic [NUM_CLR-1:0] flag_i,
    input  logic               tend_i,
    input  logic               ie_txe_i,
    input  logic               ie_rxf_i,
    input  logic               ie_err_i,
    input  logic               ie_tend_i,
    output logic               irq_txe_o,
    output logic               irq_rxf_o,
    output logic               irq_err_o,
    output logic               irq_tend_o
);

    logic any_err;

    always_comb begin
        any_err    = flag_i[IDX_OVR] | flag_i[IDX_FRM] | flag_i[IDX_PAR];
        irq_txe_o  = flag_i[IDX_TXE] & ie_txe_i;
        irq_rxf_o  = flag_i[IDX_RXF] & ie_rxf_i;
        irq_err_o  = any_err & ie_err_i;
        irq_tend_o = tend_i & ie_tend_i;
    end

endmodule

// File: rtl/serstat_flags.sv
module serstat_flags
    import serstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lowpwr_hold,
    input  logic             tx_enable,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             txe_load,
    input  logic             txe_dma_clr,
    input  logic             rxf_set,
    input  logic             ovr_set,
    input  logic             frm_set,
    input  logic             par_set,
    input  logic             tend_set,
    input  logic             tend_clr,
    input  logic             mprx_load,
    input  logic             mprx_val,
    input  logic             ie_txe,
    input  logic             ie_rxf,
    input  logic             ie_err,
    input  logic             ie_tend,
    output logic             irq_txe,
    output logic             irq_rxf,
    output logic             irq_err,
    output logic             irq_tend
);

    logic [NUM_CLR-1:0] set_v, clr_v, force_v, flag_v;
    logic tend_w, mprx_w, mptx_w;
    logic unused_ro_wbits;

    assign unused_ro_wbits = ^cpu_wdata[BIT_TEND:BIT_MPRX];

    always_comb begin
        set_v            = '0;
        set_v[IDX_TXE]   = txe_load;
        set_v[IDX_RXF]   = rxf_set;
        set_v[IDX_OVR]   = ovr_set;
        set_v[IDX_FRM]   = frm_set;
        set_v[IDX_PAR]   = par_set;
        clr_v            = '0;
        clr_v[IDX_TXE]   = txe_dma_clr;
        force_v          = '0;
        force_v[IDX_TXE] = ~tx_enable;
    end

    for (genvar i = 0; i < NUM_CLR; i++) begin : g_flag
        serstat_flag_fsm #(
            .INIT_SET (INIT_VAL[REG_W-1-i])
        ) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_i   (lowpwr_hold),
            .force_i  (force_v[i]),
            .set_i    (set_v[i]),
            .hw_clr_i (clr_v[i]),
            .rd_i     (cpu_rd),
            .wr_i     (cpu_wr),
            .wbit_i   (cpu_wdata[REG_W-1-i]),
            .flag_o   (flag_v[i])
        );
        assign cpu_rdata[REG_W-1-i] = flag_v[i];
    end

    serstat_fixed_bits u_fixed (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (lowpwr_hold),
        .wr_i        (cpu_wr),
        .wbit0_i     (cpu_wdata[BIT_MPTX]),
        .tend_set_i  (tend_set),
        .tend_clr_i  (tend_clr),
        .mprx_load_i (mprx_load),
        .mprx_val_i  (mprx_val),
        .tend_o      (tend_w),
        .mprx_o      (mprx_w),
        .mptx_o      (mptx_w)
    );

    assign cpu_rdata[BIT_TEND] = tend_w;
    assign cpu_rdata[BIT_MPRX] = mprx_w;
    assign cpu_rdata[BIT_MPTX] = mptx_w;

    serstat_irq u_irq (
        .flag_i     (flag_v),
        .tend_i     (tend_w),
        .ie_txe_i   (ie_txe),
        .ie_rxf_i   (ie_rxf),
        .ie_err_i   (ie_err),
        .ie_tend_i  (ie_tend),
        .irq_txe_o  (irq_txe),
        .irq_rxf_o  (irq_rxf),
        .irq_err_o  (irq_err),
        .irq_tend_o (irq_tend)
    );

    // R2: low-power hold loads the initial value
    a_r2_lowpwr_value: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_hold |=> (cpu_rdata == INIT_VAL));

    // R6: transmit empty held while the transmitter is off
    a_r6_txe_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> cpu_rdata[REG_W-1-IDX_TXE]);

endmodule

// File: tb/serstat_flags_tb_top.sv
`timescale 1ns/1ps
module serstat_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowpwr_hold = 1'b0, tx_enable = 1'b1;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [4:0] hw_set = 5'b0;
    logic       txe_dma_clr = 1'b0, tend_set = 1'b0, tend_clr = 1'b0;
    logic       mprx_load = 1'b0, mprx_val = 1'b0;
    logic [3:0] ie = 4'b0;
    logic       irq_txe, irq_rxf, irq_err, irq_tend;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    serstat_flags dut_i (
        .clk(clk), .rst_n(rst_n), .lowpwr_hold(lowpwr_hold), .tx_enable(tx_enable),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .txe_load(hw_set[0]), .txe_dma_clr(txe_dma_clr), .rxf_set(hw_set[1]),
        .ovr_set(hw_set[2]), .frm_set(hw_set[3]), .par_set(hw_set[4]),
        .tend_set(tend_set), .tend_clr(tend_clr), .mprx_load(mprx_load), .mprx_val(mprx_val),
        .ie_txe(ie[0]), .ie_rxf(ie[1]), .ie_err(ie[2]), .ie_tend(ie[3]),
        .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_err(irq_err), .irq_tend(irq_tend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_read();
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        cpu_wr = 1'b1; cpu_wdata = d; step(); cpu_wr = 1'b0;
    endtask

    task automatic do_hold();
        lowpwr_hold = 1'b1; step(); lowpwr_hold = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R2: reset value
        chk("R2 reset value", cpu_rdata, 8'h84);
        chk("R11 irqs off at reset", {irq_txe, irq_rxf, irq_err, irq_tend}, 4'b0);
        rst_n = 1'b1;
        step();
        chk("R1 value after reset release", cpu_rdata, 8'h84);

        // R4 R5 R8 R12: sweep each clearable flag over read/value/same-cycle set
        for (int f = 0; f < 5; f++) begin
            for (int c = 0; c < 8; c++) begin
                logic rdf, wb, ss, e1, e2;
                logic [7:0] m;
                rdf = c[0]; wb = c[1]; ss = c[2];
                m = 8'h80 >> f;
                hw_set[f] = 1'b1; step(); hw_set[f] = 1'b0;
                chk("R12 set visible next cycle", (cpu_rdata & m) != 0, 1'b1);
                if (rdf) do_read();
                cpu_wr = 1'b1;
                cpu_wdata = wb ? 8'hFF : ~m;
                hw_set[f] = ss;
                step();
                cpu_wr = 1'b0; hw_set[f] = 1'b0;
                e1 = ss | ~(rdf & ~wb);
                chk("R4 R8 armed clear sweep", (cpu_rdata & m) != 0, e1);
                do_write(~m);
                e2 = e1 & ~(rdf & wb & ~ss);
                chk("R5 second write without read", (cpu_rdata & m) != 0, e2);
                do_read();
                do_write(~m);
                chk("R4 read then clear", (cpu_rdata & m) != 0, 1'b0);
            end
        end

        // R3: CPU write of ones cannot set flags (transmit empty cleared by DMA first)
        txe_dma_clr = 1'b1; step(); txe_dma_clr = 1'b0;
        chk("R7 dma clear without read", cpu_rdata[7], 1'b0);
        do_write(8'hFF);
        chk("R3 write ones sets no flag", cpu_rdata[7:3], 5'b0);
        chk("R10 bit0 written as 1", cpu_rdata[0], 1'b1);
        do_write(8'h00);
        chk("R10 bit0 written as 0", cpu_rdata[0], 1'b0);

        // R8: load beats dma clear
        hw_set[0] = 1'b1; txe_dma_clr = 1'b1; step(); hw_set[0] = 1'b0; txe_dma_clr = 1'b0;
        chk("R8 load beats dma clear", cpu_rdata[7], 1'b1);

        // R6: transmit disabled holds transmit empty
        tx_enable = 1'b0;
        do_read();
        do_write(8'h00);
        chk("R6 cpu clear ignored while disabled", cpu_rdata[7], 1'b1);
        txe_dma_clr = 1'b1; step(); txe_dma_clr = 1'b0;
        chk("R6 dma clear ignored while disabled", cpu_rdata[7], 1'b1);
        tx_enable = 1'b1;
        txe_dma_clr = 1'b1; step(); txe_dma_clr = 1'b0;
        chk("R7 dma clear after enable", cpu_rdata[7], 1'b0);
        hw_set[0] = 1'b1; step(); hw_set[0] = 1'b0;
        chk("R6 load sets transmit empty", cpu_rdata[7], 1'b1);

        // R9: read-only bits
        mprx_load = 1'b1; mprx_val = 1'b1; step(); mprx_load = 1'b0;
        chk("R9 mp rx loaded 1", cpu_rdata[1], 1'b1);
        do_read();
        do_write(8'h01);
        chk("R9 write ignores tend and mp rx", cpu_rdata[2:1], 2'b11);
        tend_clr = 1'b1; step(); tend_clr = 1'b0;
        chk("R9 tend cleared by strobe", cpu_rdata[2], 1'b0);
        do_write(8'hFF);
        chk("R9 write cannot set tend", cpu_rdata[2], 1'b0);
        tend_set = 1'b1; tend_clr = 1'b1; step(); tend_set = 1'b0; tend_clr = 1'b0;
        chk("R9 tend set wins", cpu_rdata[2], 1'b1);
        mprx_load = 1'b1; mprx_val = 1'b0; step(); mprx_load = 1'b0;
        chk("R9 mp rx loaded 0", cpu_rdata[1], 1'b0);

        // R2: low-power hold, with strobes active during it
        hw_set = 5'b11110; mprx_load = 1'b1; mprx_val = 1'b1;
        step();
        chk("R2 flags set before hold", cpu_rdata[6:3], 4'hF);
        lowpwr_hold = 1'b1; step(); step();
        chk("R2 hold forces initial value", cpu_rdata, 8'h84);
        hw_set = 5'b0; mprx_load = 1'b0; lowpwr_hold = 1'b0;
        step();
        chk("R2 value after hold", cpu_rdata, 8'h84);

        // R11: request gating sweep over every enable pattern and error source
        for (int s = 0; s < 3; s++) begin
            do_hold();
            hw_set[1] = 1'b1; hw_set[2 + s] = 1'b1; step(); hw_set = 5'b0;
            for (int e = 0; e < 16; e++) begin
                ie = e[3:0];
                #1;
                chk("R11 request gating", {irq_tend, irq_err, irq_rxf, irq_txe}, e[3:0]);
                step();
            end
        end
        ie = 4'hF;
        do_hold();
        #1;
        chk("R11 no error request without errors", irq_err, 1'b0);
        ie = 4'h0;
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule